// File: doc/BRIEF.md
# Master clock source selector with prescaler

This block builds the master clock of a chip from one of three free-running inputs: a slow clock, a main oscillator clock and a PLL clock. The chosen input passes through a power-of-two prescaler, 1 to 64, and leaves as `mclk`. Software controls it through a single write port on the bus clock. Each write carries a source code, a prescaler code and an interrupt-enable bit.

Every accepted write clears a ready flag. The flag stays low until the new setting drives the output, then returns high. If the enable bit is set, the ready flag also drives an interrupt line. The block enforces a two-step change. A write that alters both fields applies only the prescaler, so software changes the ratio, waits for ready, and then changes the source. Source changes go through a glitch-free multiplexer. Ratio changes take effect only at a divided-period boundary.

Top module: `mclk_gen`

## Requirements
- R1: After reset `ready` is high, `irq` is low, and `mclk` follows the slow clock undivided.
- R2: Prescaler code k from 0 to 6 divides the selected source by 2^k. The reserved code 7 divides by 64.
- R3: Source code 0 selects the slow clock, 1 the main clock and 3 the PLL clock. The period of `mclk` equals the source period times the ratio.
- R4: A write taken while `ready` is high drives `ready` low on the next bus clock cycle, even when it changes nothing. `ready` returns high once the new setting drives `mclk`.
- R5: Source switching is glitch-free. At most one source gate is open at any time, and the old gate closes before the new one opens.
- R6: `irq` is high exactly when `ready` is high and the interrupt-enable bit is set. Every write updates that bit, even while `ready` is low.
- R7: A write made while `ready` is low leaves both the source and the prescaler unchanged.
- R8: A write taken while `ready` is high that would change both the source and the prescaler applies only the prescaler.
- R9: The reserved source code 2 leaves the source unchanged. The prescaler field of that write is still applied.
- R10: In divided modes, the high and low phases of `mclk` each last half the divided period. A ratio change starts a fresh period, so no phase is shorter than one source period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Clock of the write port and status logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_slow | input | 1 | Slow clock input (source code 0) |
| clk_main | input | 1 | Main oscillator clock input (source code 1) |
| clk_pll | input | 1 | PLL clock input (source code 3) |
| wr_en | input | 1 | Write strobe for the control fields |
| wr_src | input | 2 | Source code |
| wr_pre | input | 3 | Prescaler code |
| wr_irq_en | input | 1 | Ready interrupt enable |
| mclk | output | 1 | Master clock output |
| ready | output | 1 | High when the last setting drives the output |
| irq | output | 1 | Ready interrupt |

## Verification
The assertions assume that all three source clocks keep running, and that each is slow enough for a two-flop synchronizer to resolve in the bus domain. They also assume that write fields are stable around the bus clock edge. The bench keeps the source clocks running throughout and drives writes only on falling bus clock edges. Writes made while the block is busy, writes that change both fields, and writes with reserved codes are sent on purpose. The bench then checks that these writes leave the measured period of `mclk` unchanged.

// File: rtl/mclk_gen.sv
module mclk_gen (
  input  logic       bus_clk,
  input  logic       rst_n,
  input  logic       clk_slow,
  input  logic       clk_main,
  input  logic       clk_pll,
  input  logic       wr_en,
  input  logic [1:0] wr_src,
  input  logic [2:0] wr_pre,
  input  logic       wr_irq_en,
  output logic       mclk,
  output logic       ready,
  output logic       irq
);
  localparam int NSRC = 3;
  localparam int CW   = 6;

  logic [NSRC-1:0] sel_oh, en_q, en_s1, en_s;
  logic [2:0]      pre_q, pre_act;
  logic            ie_q, ready_q, req_q;
  logic            ack_q, ack_s1, ack_s, rq1, rq2, dq;
  logic [CW-1:0]   cnt;
  logic            clk_src;

  function automatic logic [NSRC-1:0] src_oh(input logic [1:0] code);
    case (code)
      2'd0:    src_oh = 3'b001;
      2'd1:    src_oh = 3'b010;
      2'd3:    src_oh = 3'b100;
      default: src_oh = 3'b000;
    endcase
  endfunction

  function automatic logic [CW-1:0] half_m1(input logic [2:0] code);
    case (code)
      3'd1:    half_m1 = 6'd0;
      3'd2:    half_m1 = 6'd1;
      3'd3:    half_m1 = 6'd3;
      3'd4:    half_m1 = 6'd7;
      3'd5:    half_m1 = 6'd15;
      3'd6:    half_m1 = 6'd31;
      3'd7:    half_m1 = 6'd31;
      default: half_m1 = 6'd0;
    endcase
  endfunction

  wire [NSRC-1:0] new_oh = src_oh(wr_src);
  wire src_chg = (new_oh != 3'b000) && (new_oh != sel_oh);
  wire pre_chg = (wr_pre != pre_q);
  wire take    = wr_en && ready_q;
  wire done    = (en_s == sel_oh) && (ack_s == req_q);

  // control and status, bus domain
  always_ff @(posedge bus_clk or negedge rst_n)
    if (!rst_n) begin
      sel_oh <= 3'b001; pre_q <= 3'd0; ie_q <= 1'b0; ready_q <= 1'b1; req_q <= 1'b0;
    end else begin
      if (wr_en) ie_q <= wr_irq_en;
      if (take) begin
        ready_q <= 1'b0;
        if (src_chg && !pre_chg) sel_oh <= new_oh;
        else begin
          pre_q <= wr_pre;
          req_q <= ~req_q;
        end
      end else if (!ready_q && done) ready_q <= 1'b1;
    end

  always_ff @(posedge bus_clk or negedge rst_n)
    if (!rst_n) begin
      en_s1 <= 3'b001; en_s <= 3'b001; ack_s1 <= 1'b0; ack_s <= 1'b0;
    end else begin
      en_s1 <= en_q; en_s <= en_s1; ack_s1 <= ack_q; ack_s <= ack_s1;
    end

  assign ready = ready_q;
  assign irq   = ready_q & ie_q;

  // glitch-free source multiplexer
  wire [NSRC-1:0] clk_in = {clk_pll, clk_main, clk_slow};

  for (genvar i = 0; i < NSRC; i++) begin : g_ch
    logic s1, s2, en;
    wire want = sel_oh[i] && ((en_q & ~(3'b1 << i)) == 3'b000);
    always_ff @(posedge clk_in[i] or negedge rst_n)
      if (!rst_n) begin s1 <= (i == 0); s2 <= (i == 0); end
      else begin s1 <= want; s2 <= s1; end
    always_ff @(negedge clk_in[i] or negedge rst_n)
      if (!rst_n) en <= (i == 0);
      else        en <= s2;
    assign en_q[i] = en;
  end

  assign clk_src = |(clk_in & en_q);

  // prescaler, source domain
  wire bypass = (pre_act == 3'd0);
  wire wrap   = (cnt == half_m1(pre_act));
  wire bound  = bypass || (wrap && !dq);

  always_ff @(posedge clk_src or negedge rst_n)
    if (!rst_n) begin
      rq1 <= 1'b0; rq2 <= 1'b0; ack_q <= 1'b0; pre_act <= 3'd0; cnt <= '0; dq <= 1'b0;
    end else begin
      rq1 <= req_q; rq2 <= rq1;
      if (bound && (rq2 != ack_q)) begin
        ack_q   <= rq2;
        pre_act <= pre_q;
        cnt     <= '0;
        dq      <= (pre_q != 3'd0);
      end else if (!bypass) begin
        cnt <= wrap ? '0 : cnt + 1'b1;
        if (wrap) dq <= ~dq;
      end
    end

  assign mclk = bypass ? clk_src : dq;

  assert_ready_drop_R4: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (wr_en && ready_q) |=> !ready_q);
  assert_busy_hold_R7: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (wr_en && !ready_q) |=> ($stable(sel_oh) && $stable(pre_q)));
  assert_both_pre_only_R8: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (take && src_chg && pre_chg) |=> $stable(sel_oh));
  assert_single_gate_R5: assert property (@(posedge bus_clk) disable iff (!rst_n)
    $onehot0(en_s));
  assert_reserved_src_R9: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (take && wr_src == 2'd2) |=> $stable(sel_oh));
endmodule

// File: tb/sim_mclk_gen.sv
`timescale 1ns/1ps
module sim_mclk_gen;
  logic bus_clk = 0, clk_slow = 0, clk_main = 0, clk_pll = 0, rst_n = 0;
  logic wr_en = 0, wr_irq_en = 0;
  logic [1:0] wr_src = 0;
  logic [2:0] wr_pre = 0;
  logic mclk, ready, irq;

  always #2.5 bus_clk = ~bus_clk;
  always #20  clk_slow = ~clk_slow;
  always #8   clk_main = ~clk_main;
  always #3   clk_pll  = ~clk_pll;

  mclk_gen u0 (.bus_clk(bus_clk), .rst_n(rst_n), .clk_slow(clk_slow), .clk_main(clk_main),
               .clk_pll(clk_pll), .wr_en(wr_en), .wr_src(wr_src), .wr_pre(wr_pre),
               .wr_irq_en(wr_irq_en), .mclk(mclk), .ready(ready), .irq(irq));

  typedef struct { real per; string tag; } item_t;
  item_t q[$];
  int n_push = 0, n_pop = 0, n_chk = 0, n_fail = 0;
  bit over = 0;

  task automatic chk(input bit ok, input string req, input string what, input real act, input real exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0.3f expected=%0.3f", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!over) begin
      over = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  // monitor: measures period and high phase of mclk
  initial begin
    forever begin
      real t0, th, t1, per, hi;
      wait (n_pop < n_push);
      repeat (3) @(posedge mclk);
      t0 = $realtime;
      @(negedge mclk); th = $realtime;
      @(posedge mclk); t1 = $realtime;
      per = t1 - t0; hi = th - t0;
      chk((per > q[0].per - 0.01) && (per < q[0].per + 0.01), q[0].tag, "mclk period", per, q[0].per);
      chk((hi > q[0].per/2 - 0.01) && (hi < q[0].per/2 + 0.01), "R10", "mclk high phase", hi, q[0].per/2);
      void'(q.pop_front());
      n_pop++;
    end
  end

  task automatic expect_per(input real per, input string tag);
    item_t it;
    it.per = per; it.tag = tag;
    q.push_back(it);
    n_push++;
    wait (n_pop == n_push);
  endtask

  task automatic wr(input logic [1:0] s, input logic [2:0] p, input logic ie);
    @(negedge bus_clk);
    wr_en = 1; wr_src = s; wr_pre = p; wr_irq_en = ie;
    @(negedge bus_clk);
    wr_en = 0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 8000 && !ready; i++) @(negedge bus_clk);
    chk(ready, "R4", "ready returns", real'(ready), 1.0);
  endtask

  initial begin
    #900us;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_pop, n_push);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge bus_clk);
    rst_n = 1;
    @(negedge bus_clk);
    chk(ready, "R1", "ready after reset", real'(ready), 1.0);
    chk(!irq, "R1", "irq after reset", real'(irq), 0.0);
    expect_per(40.0, "R1");

    wr(2'd0, 3'd2, 1'b0);
    chk(!ready, "R4", "ready low after write", real'(ready), 0.0);
    wait_ready();
    expect_per(160.0, "R2");

    wr(2'd0, 3'd1, 1'b1);
    chk(!irq, "R6", "irq low while busy", real'(irq), 0.0);
    wr(2'd0, 3'd5, 1'b1);
    chk(!ready, "R7", "still busy", real'(ready), 0.0);
    wait_ready();
    chk(irq, "R6", "irq with enable", real'(irq), 1.0);
    expect_per(80.0, "R7");

    wr(2'd1, 3'd0, 1'b1);
    wait_ready();
    expect_per(40.0, "R8");

    wr(2'd1, 3'd0, 1'b0);
    wait_ready();
    chk(!irq, "R6", "irq without enable", real'(irq), 0.0);
    expect_per(16.0, "R3");

    wr(2'd1, 3'd7, 1'b0);
    wait_ready();
    expect_per(1024.0, "R2");

    wr(2'd3, 3'd7, 1'b0);
    wait_ready();
    expect_per(384.0, "R3");

    wr(2'd2, 3'd3, 1'b0);
    wait_ready();
    expect_per(48.0, "R9");

    wr(2'd3, 3'd3, 1'b0);
    chk(!ready, "R4", "ready low on unchanged write", real'(ready), 0.0);
    wait_ready();
    expect_per(48.0, "R4");

    wr(2'd3, 3'd0, 1'b0);
    wait_ready();
    expect_per(6.0, "R2");

    wr(2'd0, 3'd0, 1'b0);
    wait_ready();
    expect_per(40.0, "R5");

    wr(2'd1, 3'd0, 1'b0);
    wait_ready();
    expect_per(16.0, "R5");

    finish_run();
  end
endmodule